// File: doc/BRIEF.md
# Variable-Length Instruction Fetch and Decode Unit

This unit sits between an 8-bit-wide program memory and the execution datapath of a small processor. Each instruction is either one byte or two bytes long. The unit reads the first byte into a head register. From the top bit of that byte it decides whether it must also read a second byte into a tail register. Once the instruction is complete it presents the decoded control fields for one execute cycle. For each byte it takes from memory, it requests one program-counter increment.

When an instruction is one byte long, the tail register is loaded with all ones. That fill value is also the neutral set of modifiers, so short instructions need no separate default path. An all-ones tail selects the unary ALU function, reads memory without writing, selects the zero page and zero bank, and targets the internal register set. Two of the eight opcode values are reserved. They pass through execute as no-operations with every write enable low.

Top module: `instr_fetch_decoder`

## Requirements
- R1: While reset is high, `pc_inc`, `exec_stb`, `mem_we`, `acc_load` and `dst_we` are all 0. In the first cycle after reset is released, `pc_inc` is 1 and `exec_stb` is 0.
- R2: A head byte with bit 7 = 1 is a complete instruction. `exec_stb` rises in the cycle right after the head fetch, and exactly one `pc_inc` pulse belongs to that instruction.
- R3: A head byte with bit 7 = 0 causes one further fetch cycle, with `pc_inc` = 1 and `exec_stb` = 0. `exec_stb` follows in the next cycle, so two `pc_inc` pulses belong to the instruction.
- R4: For a one-byte instruction, the tail fields read as if the tail byte were 0xFF. This gives `alu_fn` = 0xF, `mem_we` = 0, `zero_page` = 1, `zero_bank` = 1 and `ext_sel` = 0.
- R5: The head byte decodes as follows. `opcode` = {~bit7, bit6, bit5}, `src_sel` = bits 4:3 and `dst_sel` = bits 2:0. The opcode codes are 0 load operand, 1 conditional load, 2 move, 3 unary ALU, 4 nibble ALU and 5 byte ALU.
- R6: For a two-byte instruction the tail byte decodes as follows. `alu_fn` = bits 7:4. `mem_we` = NOT bit 3 (qualified as in R9). `zero_page` = bit 2, `zero_bank` = bit 1 and `ext_sel` = NOT bit 0.
- R7: `acc_load` is 1 exactly in the execute cycle of opcodes 3, 4 and 5.
- R8: Opcodes 6 and 7 are no-operations: `mem_we`, `acc_load` and `dst_we` remain 0 in their execute cycle.
- R9: `dst_we` is 1 exactly in the execute cycle of opcodes 0 to 5. `mem_we` is 1 only in an execute cycle of such an opcode.
- R10: `exec_stb` lasts one cycle and never coincides with `pc_inc`. The cycle after it is the head fetch of the next instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pm_data | input | 8 | Byte read from program memory at the current program counter |
| pc_inc | output | 1 | Byte consumed this cycle; advance the program counter |
| exec_stb | output | 1 | Decoded instruction is valid this cycle |
| opcode | output | 3 | Decoded operation code |
| src_sel | output | 2 | Data source select |
| dst_sel | output | 3 | Destination register index |
| alu_fn | output | 4 | ALU function code |
| mem_we | output | 1 | Memory write enable (active high) |
| zero_page | output | 1 | Force the zero page for memory access |
| zero_bank | output | 1 | Force the zero bank for memory access |
| ext_sel | output | 1 | Target the external register set |
| acc_load | output | 1 | Load the accumulator with the ALU result |
| dst_we | output | 1 | Write the destination register |

## Verification
In the execute cycle of a two-byte ALU instruction whose tail write bit is 0, the accumulator load and the memory write both assert. The bench provokes this with nibble and byte ALU instructions whose tail byte has bit 3 clear. A scoreboard entry, computed from the raw bytes, expects `acc_load`, `mem_we` and `dst_we` together. The same cycle is compared against reserved opcodes that carry the same tail byte, where all three enables must stay low. The monitor also counts `pc_inc` pulses between execute strobes, so the length decision is checked on every instruction.

// File: rtl/ifd_pkg.sv
package ifd_pkg;

    localparam int BYTE_W = 8;
    localparam int OPC_W  = 3;
    localparam int SRC_W  = 2;
    localparam int DST_W  = 3;
    localparam int FN_W   = 4;
    localparam int LEN_BIT = BYTE_W - 1;
    localparam logic [BYTE_W-1:0] TAIL_FILL = {BYTE_W{1'b1}};

    typedef enum logic [1:0] {
        ST_FETCH1 = 2'd0,
        ST_FETCH2 = 2'd1,
        ST_EXEC   = 2'd2
    } seq_state_e;

    typedef enum logic [OPC_W-1:0] {
        OP_LOAD   = 3'd0,
        OP_LOADC  = 3'd1,
        OP_MOVE   = 3'd2,
        OP_UNARY  = 3'd3,
        OP_NIBBLE = 3'd4,
        OP_BYTE   = 3'd5,
        OP_RSV6   = 3'd6,
        OP_RSV7   = 3'd7
    } opcode_e;

    typedef struct packed {
        opcode_e            op;
        logic [SRC_W-1:0]   src;
        logic [DST_W-1:0]   dst;
    } head_t;

    // Packed so that a raw tail byte maps field for field.
    typedef struct packed {
        logic [FN_W-1:0] fn;
        logic            we_n;
        logic            zp;
        logic            zb;
        logic            ext_n;
    } tail_t;

    function automatic head_t split_head(input logic [BYTE_W-1:0] b);
        head_t h;
        h.op  = opcode_e'({~b[LEN_BIT], b[LEN_BIT-1 -: OPC_W-1]});
        h.src = b[DST_W +: SRC_W];
        h.dst = b[DST_W-1:0];
        return h;
    endfunction

    function automatic logic op_defined(input opcode_e op);
        return (op != OP_RSV6) && (op != OP_RSV7);
    endfunction

    function automatic logic op_uses_alu(input opcode_e op);
        return (op == OP_UNARY) || (op == OP_NIBBLE) || (op == OP_BYTE);
    endfunction

endpackage

// File: rtl/ifd_sequencer.sv
module ifd_sequencer
    import ifd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic short_flag,
    output logic load_head,
    output logic load_tail,
    output logic inc_o,
    output logic exec_o
);

    seq_state_e state, state_nx;

    always_comb begin
        case (state)
            ST_FETCH1: state_nx = short_flag ? ST_EXEC : ST_FETCH2;
            ST_FETCH2: state_nx = ST_EXEC;
            ST_EXEC:   state_nx = ST_FETCH1;
            default:   state_nx = ST_FETCH1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_FETCH1;
        else     state <= state_nx;
    end

    assign load_head = (state == ST_FETCH1) && !rst;
    assign load_tail = (state == ST_FETCH2) && !rst;
    assign inc_o     = load_head || load_tail;
    assign exec_o    = (state == ST_EXEC) && !rst;

    // R2
    short_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        (load_head && short_flag) |=> (exec_o && !inc_o));

    // R3
    long_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        (load_head && !short_flag) |=> (inc_o && !exec_o));

    // R3
    tail_then_exec_chk: assert property (@(posedge clk) disable iff (rst)
        load_tail |=> exec_o);

    // R10
    exec_then_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        exec_o |=> (load_head && !exec_o));

endmodule

// File: rtl/ifd_irregs.sv
module ifd_irregs
    import ifd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_head,
    input  logic              load_tail,
    input  logic [BYTE_W-1:0] pm_data,
    output logic [BYTE_W-1:0] head_q,
    output logic [BYTE_W-1:0] tail_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= TAIL_FILL;
            tail_q <= TAIL_FILL;
        end else begin
            if (load_head) begin
                head_q <= pm_data;
                tail_q <= TAIL_FILL;
            end
            if (load_tail) begin
                tail_q <= pm_data;
            end
        end
    end

    // R4
    short_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (load_head && pm_data[LEN_BIT]) |=> (tail_q == TAIL_FILL));

endmodule

// File: rtl/ifd_field_decode.sv
module ifd_field_decode
    import ifd_pkg::*;
(
    input  logic              exec_i,
    input  logic [BYTE_W-1:0] head_i,
    input  logic [BYTE_W-1:0] tail_i,
    output logic [OPC_W-1:0]  op_o,
    output logic [SRC_W-1:0]  src_o,
    output logic [DST_W-1:0]  dst_o,
    output logic [FN_W-1:0]   fn_o,
    output logic              zp_o,
    output logic              zb_o,
    output logic              ext_o,
    output logic              mem_we_o,
    output logic              acc_o,
    output logic              dst_we_o
);

    head_t h;
    tail_t t;
    logic  live;

    always_comb begin
        h        = split_head(head_i);
        t        = tail_t'(tail_i);
        live     = exec_i && op_defined(h.op);
        op_o     = h.op;
        src_o    = h.src;
        dst_o    = h.dst;
        fn_o     = t.fn;
        zp_o     = t.zp;
        zb_o     = t.zb;
        ext_o    = ~t.ext_n;
        mem_we_o = live && !t.we_n;
        acc_o    = live && op_uses_alu(h.op);
        dst_we_o = live;
    end

endmodule

// File: rtl/instr_fetch_decoder.sv
module instr_fetch_decoder
    import ifd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  pm_data,
    output logic        pc_inc,
    output logic        exec_stb,
    output logic [2:0]  opcode,
    output logic [1:0]  src_sel,
    output logic [2:0]  dst_sel,
    output logic [3:0]  alu_fn,
    output logic        mem_we,
    output logic        zero_page,
    output logic        zero_bank,
    output logic        ext_sel,
    output logic        acc_load,
    output logic        dst_we
);

    logic              load_head, load_tail;
    logic [BYTE_W-1:0] head_q, tail_q;

    ifd_sequencer u_seq (
        .clk        (clk),
        .rst        (rst),
        .short_flag (pm_data[LEN_BIT]),
        .load_head  (load_head),
        .load_tail  (load_tail),
        .inc_o      (pc_inc),
        .exec_o     (exec_stb)
    );

    ifd_irregs u_ir (
        .clk       (clk),
        .rst       (rst),
        .load_head (load_head),
        .load_tail (load_tail),
        .pm_data   (pm_data),
        .head_q    (head_q),
        .tail_q    (tail_q)
    );

    ifd_field_decode u_dec (
        .exec_i   (exec_stb),
        .head_i   (head_q),
        .tail_i   (tail_q),
        .op_o     (opcode),
        .src_o    (src_sel),
        .dst_o    (dst_sel),
        .fn_o     (alu_fn),
        .zp_o     (zero_page),
        .zb_o     (zero_bank),
        .ext_o    (ext_sel),
        .mem_we_o (mem_we),
        .acc_o    (acc_load),
        .dst_we_o (dst_we)
    );

    // R8
    rsv_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (exec_stb && opcode[2:1] == 2'b11) |-> (!mem_we && !acc_load && !dst_we));

    // R7
    acc_window_chk: assert property (@(posedge clk) disable iff (rst)
        acc_load |-> (exec_stb && opcode >= 3'd3 && opcode <= 3'd5));

    // R9
    write_window_chk: assert property (@(posedge clk) disable iff (rst)
        (dst_we || mem_we) |-> exec_stb);

    // R10
    no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        !(exec_stb && pc_inc));

endmodule

// File: tb/tb_instr_fetch_decoder.sv
`timescale 1ns/1ps
module tb_instr_fetch_decoder;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] pm_data;
    logic       pc_inc, exec_stb, mem_we, zero_page, zero_bank, ext_sel, acc_load, dst_we;
    logic [2:0] opcode, dst_sel;
    logic [1:0] src_sel;
    logic [3:0] alu_fn;

    always #2.5 clk = ~clk;

    instr_fetch_decoder dut (
        .clk(clk), .rst(rst), .pm_data(pm_data), .pc_inc(pc_inc), .exec_stb(exec_stb),
        .opcode(opcode), .src_sel(src_sel), .dst_sel(dst_sel), .alu_fn(alu_fn),
        .mem_we(mem_we), .zero_page(zero_page), .zero_bank(zero_bank),
        .ext_sel(ext_sel), .acc_load(acc_load), .dst_we(dst_we)
    );

    typedef struct {
        logic [2:0] op;
        logic [1:0] src;
        logic [2:0] dst;
        logic [3:0] fn;
        logic       we, zp, zb, ext, acc, dwe;
        int         nbytes;
    } exp_t;

    exp_t       sb[$];
    logic [7:0] prog [0:255];
    int         wr_ptr = 0;
    int         pc = 0;
    int         total = 0;
    int         bad = 0;
    bit         started = 0;
    bit         done = 0;
    bit         reported = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
        end
    endtask

    // Driver: places bytes in program memory and the expected item in the scoreboard.
    task automatic push_instr(input logic [7:0] b1, input logic [7:0] b2);
        exp_t       e;
        logic [7:0] t;
        bit         defined;
        prog[wr_ptr] = b1;
        wr_ptr++;
        if (b1[7]) begin
            t = 8'hFF;
            e.nbytes = 1;
        end else begin
            prog[wr_ptr] = b2;
            wr_ptr++;
            t = b2;
            e.nbytes = 2;
        end
        e.op  = {~b1[7], b1[6:5]};
        e.src = b1[4:3];
        e.dst = b1[2:0];
        e.fn  = t[7:4];
        e.zp  = t[2];
        e.zb  = t[1];
        e.ext = ~t[0];
        defined = (e.op < 3'd6);
        e.we  = defined && !t[3];
        e.acc = (e.op >= 3'd3) && (e.op <= 3'd5);
        e.dwe = defined;
        sb.push_back(e);
    endtask

    // Program memory model: byte at pc is presented; pc advances after a consumed byte.
    initial begin
        bit adv;
        pm_data = 8'h80;
        forever begin
            @(negedge clk);
            #1;
            adv = pc_inc && !rst;
            @(posedge clk);
            #0.5;
            if (adv) pc++;
            pm_data = prog[pc[7:0]];
        end
    end

    // Monitor: pops scoreboard items on each execute strobe.
    initial begin
        int  incs = 0;
        bit  prev_exec = 0;
        exp_t e;
        forever begin
            @(negedge clk);
            #1;
            if (started && !done) begin
                if (prev_exec) begin
                    // R10: the cycle after execute fetches a new head byte
                    check(pc_inc == 1'b1 && exec_stb == 1'b0, "R10 fetch after exec",
                          {pc_inc, exec_stb}, 2'b10);
                end
                // R10: execute and fetch never share a cycle
                if (exec_stb && pc_inc) check(0, "R10 overlap", 1, 0);
                if (pc_inc) incs++;
                if (exec_stb) begin
                    if (sb.size() == 0) begin
                        check(0, "R10 unexpected exec", 1, 0);
                    end else begin
                        e = sb.pop_front();
                        if (e.nbytes == 1)
                            check(incs == 1, "R2 one fetch", incs, 1);
                        else
                            check(incs == 2, "R3 two fetches", incs, 2);
                        check({opcode, src_sel, dst_sel} == {e.op, e.src, e.dst}, "R5 head fields",
                              {opcode, src_sel, dst_sel}, {e.op, e.src, e.dst});
                        if (e.nbytes == 1)
                            check({alu_fn, zero_page, zero_bank, ext_sel, mem_we} ==
                                  {4'hF, 1'b1, 1'b1, 1'b0, 1'b0}, "R4 default tail",
                                  {alu_fn, zero_page, zero_bank, ext_sel, mem_we}, 8'hFC);
                        else
                            check({alu_fn, zero_page, zero_bank, ext_sel} == {e.fn, e.zp, e.zb, e.ext},
                                  "R6 tail fields", {alu_fn, zero_page, zero_bank, ext_sel},
                                  {e.fn, e.zp, e.zb, e.ext});
                        check(acc_load == e.acc, "R7 acc load", acc_load, e.acc);
                        if (e.op >= 3'd6)
                            check({mem_we, acc_load, dst_we} == 3'b000, "R8 reserved quiet",
                                  {mem_we, acc_load, dst_we}, 0);
                        else
                            check({mem_we, dst_we} == {e.we, e.dwe}, "R9 write enables",
                                  {mem_we, dst_we}, {e.we, e.dwe});
                    end
                    incs = 0;
                end
                prev_exec = exec_stb;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            check(0, "watchdog", sb.size(), 0);
            report();
            $finish;
        end
    end

    initial begin
        int unsigned seed = 32'h1234_5678;
        for (int i = 0; i < 256; i++) prog[i] = 8'h80;
        // Directed corner cases
        push_instr(8'b1_00_01_010, 8'h00);  // load operand, one byte
        push_instr(8'hFF,          8'h00);  // unary ALU, one byte, all ones
        push_instr(8'b0_00_10_101, 8'h62);  // nibble ALU with write and ext, acc+mem same cycle
        push_instr(8'b0_01_00_000, 8'h9D);  // byte ALU, read only
        push_instr(8'b0_10_01_011, 8'h00);  // reserved 6 with write bit low
        push_instr(8'h7F,          8'h30);  // reserved 7
        push_instr(8'hA4,          8'h00);  // conditional load
        push_instr(8'hC9,          8'h00);  // move
        push_instr(8'h3E,          8'hFF);  // byte ALU with explicit all-ones tail
        push_instr(8'b0_01_11_110, 8'h50);  // byte ALU, write, zero page/bank off
        push_instr(8'h80,          8'h00);
        push_instr(8'h80,          8'h00);
        // Pseudo-random stream
        for (int k = 0; k < 40; k++) begin
            logic [7:0] a, b;
            seed = seed * 32'd1103515245 + 32'd12345;
            a = seed[23:16];
            b = seed[31:24];
            if (wr_ptr < 250) push_instr(a, b);
        end

        // R1: outputs quiet during reset
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        check({pc_inc, exec_stb, mem_we, acc_load, dst_we} == 5'b0, "R1 reset quiet",
              {pc_inc, exec_stb, mem_we, acc_load, dst_we}, 0);
        @(negedge clk);
        rst = 1'b0;
        started = 1;
        #0.5;
        // R1: first cycle after reset fetches
        check(pc_inc == 1'b1 && exec_stb == 1'b0, "R1 first fetch", {pc_inc, exec_stb}, 2'b10);

        wait (sb.size() == 0);
        done = 1;
        repeat (2) @(posedge clk);
        report();
        $finish;
    end

endmodule